// File: doc/BRIEF.md
# Command Mailbox with Sticky Status

This block carries short commands between an operating system and a system-management handler. It holds two byte-wide mailbox registers, one for each direction. Writing a mailbox also has a side effect. A write to the inbound mailbox latches a command flag and raises a management-interrupt request. A write to the outbound mailbox latches a reply flag and raises one of four ordinary interrupt lines, picked by a small select register.

A 16-bit status register collects these flags. It also latches two external event inputs: a system-error message and an NMI message. Every flag is sticky and clears only when software writes a one to its position. If a set and a clear fall in the same cycle, the set wins. Reads go through a registered read port, and the data appears one cycle after the request.

Top module: `cmd_mailbox`

## Requirements
- R1: After a synchronous active-high reset, both mailboxes read 00h, status reads 0000h and the select field reads 0. `smi_req` and all bits of `irq_line` are low.
- R2: A write to offset 2 stores `wdata[7:0]` in the inbound mailbox and sets status bit 0. The inbound mailbox reads back at offset 2.
- R3: `smi_req` is high in every cycle that status bit 0 is set, starting the cycle after the setting write.
- R4: A write to offset 3 stores `wdata[7:0]` in the outbound mailbox and sets status bit 1. The outbound mailbox reads back at offset 3.
- R5: The select field is `wdata[1:0]` written at offset 6. While status bit 1 is set, `irq_line[sel]` is high and the other lines are low. While status bit 1 is clear, all lines are low.
- R6: A cycle with `serr_evt` high sets status bit 12. A cycle with `nmi_evt` high sets status bit 11.
- R7: A write to offset 4 clears each status bit whose `wdata` bit is 1. Bits written with 0 keep their value.
- R8: If a set event and a clear of the same status bit happen in one cycle, the bit ends up set.
- R9: Status bits 15:13 and the other unused status bits always read 0. Mailbox reads return 0 in bits 15:8. Unmapped offsets read 0000h.
- R10: `rdata` carries the register value as it stood before the edge at which `rd_en` was sampled. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| serr_evt | input | 1 | System-error message received |
| nmi_evt | input | 1 | NMI message received |
| smi_req | output | 1 | Management-interrupt request |
| irq_line | output | 4 | Routed outbound interrupt lines |

## Verification
Two things can collide in one cycle: a status flag being set, and the same flag being cleared by a write-one. The set can come from a mailbox write or from an event input. Both collisions are provoked on purpose. The bench pulses `serr_evt` or `nmi_evt` while a clear write to offset 4 hits the same bit. The random phase also produces such collisions freely.

The outcome is judged from a status read and from the `smi_req` and `irq_line` levels. These are compared to a bench model that applies the clear first and then the set.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W  = 8;
  localparam int STS_W   = 16;
  localparam int RDATA_W = 16;

  localparam logic [2:0] OFS_INBOX  = 3'd2;
  localparam logic [2:0] OFS_OUTBOX = 3'd3;
  localparam logic [2:0] OFS_STATUS = 3'd4;
  localparam logic [2:0] OFS_SELECT = 3'd6;

  localparam int BIT_CMD  = 0;
  localparam int BIT_RPLY = 1;
  localparam int BIT_NMI  = 11;
  localparam int BIT_SERR = 12;

  localparam logic [STS_W-1:0] STS_MASK =
    (STS_W'(1) << BIT_CMD) | (STS_W'(1) << BIT_RPLY) |
    (STS_W'(1) << BIT_NMI) | (STS_W'(1) << BIT_SERR);
endpackage

// File: rtl/mbx_status.sv
module mbx_status
  import mbx_pkg::*;
#(
  parameter int W = STS_W,
  parameter logic [W-1:0] MASK = STS_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] sts_d,
  output logic [W-1:0] sts_q
);
  // Clear applied first, then set, so a same-cycle set dominates.
  always_comb sts_d = ((sts_q & ~clr_vec) | set_vec) & MASK;

  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= sts_d;
  end
endmodule

// File: rtl/mbx_irq_route.sv
module mbx_irq_route #(
  parameter int LINES = 4,
  localparam int SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             flag_d,
  output logic [SEL_W-1:0] sel_q,
  output logic [LINES-1:0] line_q
);
  logic [SEL_W-1:0] sel_d;
  logic [LINES-1:0] dec;

  always_comb sel_d = sel_we ? sel_wdata : sel_q;

  for (genvar i = 0; i < LINES; i++) begin : g_dec
    assign dec[i] = flag_d && (sel_d == SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      line_q <= '0;
    end else begin
      sel_q  <= sel_d;
      line_q <= dec;
    end
  end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int LINES  = 4,
  localparam int SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [RDATA_W-1:0] wdata,
  output logic [RDATA_W-1:0] rdata,
  input  logic               serr_evt,
  input  logic               nmi_evt,
  output logic               smi_req,
  output logic [LINES-1:0]   irq_line
);
  logic [DATA_W-1:0]  inbox_q, outbox_q;
  logic [STS_W-1:0]   set_vec, clr_vec, sts_d, sts_q;
  logic [SEL_W-1:0]   sel_q;
  logic               wr_in, wr_out, wr_sts, wr_sel;
  logic [RDATA_W-1:0] rd_mux;

  assign wr_in  = wr_en && (addr == ADDR_W'(OFS_INBOX));
  assign wr_out = wr_en && (addr == ADDR_W'(OFS_OUTBOX));
  assign wr_sts = wr_en && (addr == ADDR_W'(OFS_STATUS));
  assign wr_sel = wr_en && (addr == ADDR_W'(OFS_SELECT));

  always_comb begin
    set_vec = '0;
    set_vec[BIT_CMD]  = wr_in;
    set_vec[BIT_RPLY] = wr_out;
    set_vec[BIT_NMI]  = nmi_evt;
    set_vec[BIT_SERR] = serr_evt;
    clr_vec = wr_sts ? wdata[STS_W-1:0] : '0;
  end

  mbx_status #(.W(STS_W), .MASK(STS_MASK)) u_sts (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .sts_d(sts_d), .sts_q(sts_q)
  );

  mbx_irq_route #(.LINES(LINES)) u_route (
    .clk(clk), .rst(rst), .sel_we(wr_sel), .sel_wdata(wdata[SEL_W-1:0]),
    .flag_d(sts_d[BIT_RPLY]), .sel_q(sel_q), .line_q(irq_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      inbox_q  <= '0;
      outbox_q <= '0;
      smi_req  <= 1'b0;
    end else begin
      if (wr_in)  inbox_q  <= wdata[DATA_W-1:0];
      if (wr_out) outbox_q <= wdata[DATA_W-1:0];
      smi_req <= sts_d[BIT_CMD];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(OFS_INBOX):  rd_mux = RDATA_W'(inbox_q);
      ADDR_W'(OFS_OUTBOX): rd_mux = RDATA_W'(outbox_q);
      ADDR_W'(OFS_STATUS): rd_mux = RDATA_W'(sts_q);
      ADDR_W'(OFS_SELECT): rd_mux = RDATA_W'(sel_q);
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int LINES  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [RDATA_W-1:0] wdata,
  input logic [RDATA_W-1:0] rdata,
  input logic               serr_evt,
  input logic               nmi_evt,
  input logic               smi_req,
  input logic [LINES-1:0]   irq_line,
  input logic [STS_W-1:0]   sts_q
);
  a_r3_smi_after_inbox: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFS_INBOX)) |=> smi_req);

  a_r3_smi_tracks_flag: assert property (@(posedge clk) disable iff (rst)
    smi_req == sts_q[BIT_CMD]);

  a_r5_one_line: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_line) && ((irq_line != '0) == sts_q[BIT_RPLY]));

  a_r6_serr_sets: assert property (@(posedge clk) disable iff (rst)
    serr_evt |=> sts_q[BIT_SERR]);

  a_r6_nmi_sets: assert property (@(posedge clk) disable iff (rst)
    nmi_evt |=> sts_q[BIT_NMI]);

  a_r7_clear_serr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFS_STATUS) && wdata[BIT_SERR] && !serr_evt)
      |=> !sts_q[BIT_SERR]);

  a_r7_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFS_STATUS) && !wdata[BIT_NMI] && sts_q[BIT_NMI])
      |=> sts_q[BIT_NMI]);

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OFS_STATUS)) |=> (rdata[15:13] == 3'b000));
endmodule

bind cmd_mailbox mbx_checker #(.ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .serr_evt(serr_evt), .nmi_evt(nmi_evt),
  .smi_req(smi_req), .irq_line(irq_line), .sts_q(u_sts.sts_q)
);

// File: tb/sim_cmd_mailbox.sv
module sim_cmd_mailbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, serr_evt = 1'b0, nmi_evt = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        smi_req;
  logic [3:0]  irq_line;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_in, m_out;
  logic [15:0] m_sts;
  logic [1:0]  m_sel;
  logic [15:0] m_rd;

  always #5 clk = ~clk;

  cmd_mailbox u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .serr_evt(serr_evt), .nmi_evt(nmi_evt),
    .smi_req(smi_req), .irq_line(irq_line)
  );

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd2:    return {8'h00, m_in};
      3'd3:    return {8'h00, m_out};
      3'd4:    return m_sts;
      3'd6:    return {14'h0, m_sel};
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [3:0] m_lines();
    return m_sts[1] ? (4'b0001 << m_sel) : 4'b0000;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    check({tag, " R3 smi_req"}, {15'h0, smi_req}, {15'h0, m_sts[0]});
    check({tag, " R5 irq_line"}, {12'h0, irq_line}, {12'h0, m_lines()});
    check({tag, " R10 rdata"}, rdata, m_rd);
  endtask

  // Drive one cycle at negedge, model the following posedge, check at next negedge.
  task automatic cyc(input logic w, input logic r, input logic [2:0] a,
                     input logic [15:0] d, input logic se, input logic nm);
    logic [15:0] clr, set;
    wr_en = w; rd_en = r; addr = a; wdata = d; serr_evt = se; nmi_evt = nm;
    if (r) m_rd = m_read(a);
    clr = (w && a == 3'd4) ? d : 16'h0;
    set = 16'h0;
    set[0]  = w && a == 3'd2;
    set[1]  = w && a == 3'd3;
    set[11] = nm;
    set[12] = se;
    m_sts = ((m_sts & ~clr) | set) & 16'h1803;
    if (w && a == 3'd2) m_in  = d[7:0];
    if (w && a == 3'd3) m_out = d[7:0];
    if (w && a == 3'd6) m_sel = d[1:0];
    @(negedge clk);
    wr_en = 0; rd_en = 0; serr_evt = 0; nmi_evt = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
    cyc(0, 1, a, 16'h0, 0, 0);
    check(req, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    m_in = 0; m_out = 0; m_sts = 0; m_sel = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 smi_req", {15'h0, smi_req}, 16'h0);
    check("R1 irq_line", {12'h0, irq_line}, 16'h0);
    rd_chk(3'd2, 16'h0000, "R1 inbox");
    rd_chk(3'd3, 16'h0000, "R1 outbox");
    rd_chk(3'd4, 16'h0000, "R1 status");
    rd_chk(3'd6, 16'h0000, "R1 select");
    // R2 R3 inbound
    cyc(1, 0, 3'd2, 16'hFFA5, 0, 0);
    check("R3 smi high after write", {15'h0, smi_req}, 16'h1);
    rd_chk(3'd2, 16'h00A5, "R2 R9 inbox readback");
    rd_chk(3'd4, 16'h0001, "R2 status bit0");
    // R4 R5 outbound with select 2
    cyc(1, 0, 3'd6, 16'hFFFE, 0, 0);
    rd_chk(3'd6, 16'h0002, "R5 select readback");
    cyc(1, 0, 3'd3, 16'h003C, 0, 0);
    check("R5 line 2", {12'h0, irq_line}, 16'h0004);
    rd_chk(3'd4, 16'h0003, "R4 status bit1");
    cyc(1, 0, 3'd6, 16'h0001, 0, 0);
    check("R5 reroute line 1", {12'h0, irq_line}, 16'h0002);
    // R6 events
    cyc(0, 0, 3'd0, 16'h0, 1, 0);
    cyc(0, 0, 3'd0, 16'h0, 0, 1);
    rd_chk(3'd4, 16'h1803, "R6 serr nmi latched");
    // R7 write zero keeps, write one clears
    cyc(1, 0, 3'd4, 16'h0000, 0, 0);
    rd_chk(3'd4, 16'h1803, "R7 zero no effect");
    cyc(1, 0, 3'd4, 16'h0001, 0, 0);
    check("R7 smi drops", {15'h0, smi_req}, 16'h0);
    rd_chk(3'd4, 16'h1802, "R7 clear bit0");
    // R8 set wins over clear
    cyc(1, 0, 3'd4, 16'h1800, 1, 1);
    rd_chk(3'd4, 16'h1802, "R8 event beats clear");
    cyc(1, 0, 3'd4, 16'hFFFF, 0, 0);
    rd_chk(3'd4, 16'h0000, "R7 R9 clear all");
    check("R5 lines off", {12'h0, irq_line}, 16'h0);
    rd_chk(3'd7, 16'h0000, "R9 unmapped");
    // R10 hold
    cyc(0, 0, 3'd2, 16'h0, 0, 0);
    check("R10 rdata holds", rdata, 16'h0000);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic [15:0] d;
      logic w, r;
      a = 3'($urandom_range(1, 7));
      d = 16'($urandom);
      w = ($urandom_range(0, 3) != 0);
      r = ($urandom_range(0, 1) != 0);
      cyc(w, r, a, d, ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0));
      check_outs("rand R8");
    end
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule